// File: doc/BRIEF.md
# Processor Status Word and Single-Step Trap Unit

This block holds the 16-bit status and control word of a processor core. The execution unit writes the six arithmetic result bits through per-bit strobes. The instruction pipeline issues commands that set or clear the interrupt-enable bit, and it loads the whole word from a stack image when flags are popped or a handler returns. The block drives the external-interrupt enable and the string-direction control straight from the stored word.

The block also runs single-stepping. While the trap bit is set, each retired instruction raises a one-cycle trap request. At the same time the block captures the image that the trap entry pushes, with the trap bit set, and clears the live trap bit. The handler therefore runs without being stepped. Reloading the pushed image at handler return arms the trap again. In protected mode, a privilege check guards every change to the interrupt-enable bit. The trap bit is never gated this way.

The only data leaving the block is the pushed image. It is qualified by the one-cycle trap request and has no ready input, so it has no back-pressure. The stack logic must take the image in the cycle the request is high, or read it later: the image holds its value until the next trap.

Top module: `flag_word_unit`

## Requirements
- R1: After reset every bit of the word is 0. Bits 1, 3, 5 and 15 always read 0, including after an image load that has them set.
- R2: Strobe bit i of `st_we_i` (i = 0..5) writes `st_val_i[i]` into word bit 0, 2, 4, 6, 7 or 11 respectively (carry, parity, aux carry, zero, sign, overflow). The new value is visible one cycle later. An image load in the same cycle overrides the strobes.
- R3: An image load copies bits 0, 2, 4, 6, 7, 8, 10, 11 and 12 to 14 (I/O privilege in 13:12, nested task in 14) from `img_i` into the word on the next cycle. Bit 9 follows R5.
- R4: `ie_set_i` makes bit 9 equal 1 and `ie_clr_i` makes it 0 on the next cycle. Clear wins when both are asserted. An image load in the same cycle takes precedence. `int_en_o` equals bit 9.
- R5: The privilege check passes when `pmode_i` is 0 or `cpl_i` <= word bits 13:12. If it fails, a set or clear command leaves bit 9 unchanged and raises `prot_fault_o` for exactly the next cycle. An image load then keeps the old bit 9 without a fault, while its other bits still load.
- R6: Only an image load changes the trap bit (bit 8) to 1. A retire in the same cycle as the load does not trap. The first retire after it does.
- R7: A retire while the stored bit 8 is 1 makes `trap_req_o` high for exactly the next cycle. In that cycle `push_img_o` equals the word after that cycle's updates with bit 8 forced to 1, and the live bit 8 reads 0. `push_img_o` holds its value until the next trap.
- R8: Trapping and trap-bit loads are independent of `pmode_i` and `cpl_i`.
- R9: `dir_dec_o` equals word bit 10 (1 = decrement string addresses, 0 = increment).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One instruction retired this cycle |
| st_we_i | input | 6 | Status-bit write strobes |
| st_val_i | input | 6 | New status-bit values |
| ie_set_i | input | 1 | Set interrupt-enable command |
| ie_clr_i | input | 1 | Clear interrupt-enable command |
| img_ld_i | input | 1 | Load the word from a stack image |
| img_i | input | 16 | Stack image to load |
| cpl_i | input | 2 | Current privilege level |
| pmode_i | input | 1 | Protected mode active |
| flags_o | output | 16 | Stored status and control word |
| int_en_o | output | 1 | External interrupts accepted |
| dir_dec_o | output | 1 | String direction: 1 decrement |
| trap_req_o | output | 1 | Single-step trap request pulse |
| push_img_o | output | 16 | Image to push on trap entry |
| prot_fault_o | output | 1 | Privilege fault on interrupt-enable command |

## Verification
Every result of this block is due exactly one clock after the edge that samples its stimulus. This covers the word, its two decoded controls, the fault pulse, the trap pulse and the pushed image. The bench applies inputs at the falling edge and steps a reference model at the rising edge. It compares all outputs 1 ns after that rising edge, while the inputs are still held, so each check sees exactly one cycle of stimulus. The trap delay is checked as a count of retires rather than cycles: the directed sequences load the trap bit together with a retire and expect the pulse only after the following retire.

// File: rtl/flg_pkg.sv
package flg_pkg;
  localparam int FW  = 16;
  localparam int NST = 6;
  localparam int B_CF = 0;
  localparam int B_PF = 2;
  localparam int B_AF = 4;
  localparam int B_ZF = 6;
  localparam int B_SF = 7;
  localparam int B_TF = 8;
  localparam int B_IE = 9;
  localparam int B_DF = 10;
  localparam int B_OF = 11;
  localparam int B_PL = 12;
  localparam int PLW  = 2;
  localparam logic [FW-1:0] DEF_MASK = 16'h7FD5;

  // strobe index -> word bit position
  function automatic int st_pos(input int i);
    case (i)
      0: return B_CF;
      1: return B_PF;
      2: return B_AF;
      3: return B_ZF;
      4: return B_SF;
      default: return B_OF;
    endcase
  endfunction
endpackage

// File: rtl/flg_priv_gate.sv
module flg_priv_gate
  import flg_pkg::*;
(
  input  logic           pmode_i,
  input  logic [PLW-1:0] cpl_i,
  input  logic [PLW-1:0] iopl_i,
  output logic           ok_o
);
  assign ok_o = !pmode_i || (cpl_i <= iopl_i);
endmodule

// File: rtl/flg_status_merge.sv
module flg_status_merge
  import flg_pkg::*;
(
  input  logic [FW-1:0]  cur_i,
  input  logic [NST-1:0] we_i,
  input  logic [NST-1:0] val_i,
  output logic [FW-1:0]  word_o
);
  logic [NST-1:0][FW-1:0] stage;

  for (genvar g = 0; g < NST; g++) begin : g_bit
    localparam int P = st_pos(g);
    logic [FW-1:0] prev;
    if (g == 0) begin : g_first
      assign prev = cur_i;
    end else begin : g_rest
      assign prev = stage[g-1];
    end
    always_comb begin
      stage[g]    = prev;
      stage[g][P] = we_i[g] ? val_i[g] : prev[P];
    end
  end

  assign word_o = stage[NST-1];
endmodule

// File: rtl/flg_trap_ctl.sv
module flg_trap_ctl
  import flg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_i,
  input  logic [FW-1:0] nxt_i,
  output logic          trap_req_o,
  output logic [FW-1:0] push_img_o
);
  logic [FW-1:0] push_d;

  always_comb begin
    push_d       = nxt_i;
    push_d[B_TF] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_req_o <= 1'b0;
      push_img_o <= '0;
    end else begin
      trap_req_o <= fire_i;
      if (fire_i) push_img_o <= push_d;
    end
  end
endmodule

// File: rtl/flag_word_unit.sv
module flag_word_unit
  import flg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                retire_i,
  input  logic [NST-1:0]      st_we_i,
  input  logic [NST-1:0]      st_val_i,
  input  logic                ie_set_i,
  input  logic                ie_clr_i,
  input  logic                img_ld_i,
  input  logic [FW-1:0]       img_i,
  input  logic [PLW-1:0]      cpl_i,
  input  logic                pmode_i,
  output logic [FW-1:0]       flags_o,
  output logic                int_en_o,
  output logic                dir_dec_o,
  output logic                trap_req_o,
  output logic [FW-1:0]       push_img_o,
  output logic                prot_fault_o
);
  logic [FW-1:0] word_q, merged, nxt, word_d;
  logic          ok, ie_cmd, fire;

  flg_priv_gate u_gate (
    .pmode_i (pmode_i),
    .cpl_i   (cpl_i),
    .iopl_i  (word_q[B_PL +: PLW]),
    .ok_o    (ok)
  );

  flg_status_merge u_merge (
    .cur_i  (word_q),
    .we_i   (st_we_i),
    .val_i  (st_val_i),
    .word_o (merged)
  );

  assign ie_cmd = ie_set_i | ie_clr_i;
  assign fire   = retire_i & word_q[B_TF];

  always_comb begin
    if (img_ld_i) begin
      nxt       = img_i & DEF_MASK;
      nxt[B_IE] = ok ? img_i[B_IE] : word_q[B_IE];
    end else begin
      nxt = merged;
      if (ie_cmd && ok) nxt[B_IE] = ~ie_clr_i;
    end
    word_d = nxt;
    if (fire) word_d[B_TF] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q       <= '0;
      prot_fault_o <= 1'b0;
    end else begin
      word_q       <= word_d & DEF_MASK;
      prot_fault_o <= ie_cmd & ~ok;
    end
  end

  flg_trap_ctl u_trap (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_i     (fire),
    .nxt_i      (nxt & DEF_MASK),
    .trap_req_o (trap_req_o),
    .push_img_o (push_img_o)
  );

  assign flags_o   = word_q;
  assign int_en_o  = word_q[B_IE];
  assign dir_dec_o = word_q[B_DF];
endmodule

// File: rtl/flg_chk.sv
module flg_chk
  import flg_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           retire_i,
  input logic [NST-1:0] st_we_i,
  input logic [NST-1:0] st_val_i,
  input logic           ie_set_i,
  input logic           ie_clr_i,
  input logic           img_ld_i,
  input logic [FW-1:0]  img_i,
  input logic [PLW-1:0] cpl_i,
  input logic           pmode_i,
  input logic [FW-1:0]  flags_o,
  input logic           int_en_o,
  input logic           dir_dec_o,
  input logic           trap_req_o,
  input logic [FW-1:0]  push_img_o,
  input logic           prot_fault_o
);
  a_r4_set_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_set_i && !ie_clr_i && !img_ld_i && (!pmode_i || cpl_i <= flags_o[13:12]))
    |=> int_en_o);

  a_r5_denied_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ((ie_set_i || ie_clr_i) && pmode_i && cpl_i > flags_o[13:12] && !img_ld_i)
    |=> (prot_fault_o && $stable(int_en_o)));

  a_r6_trap_bit_source: assert property (@(posedge clk) disable iff (!rst_n)
    !img_ld_i |=> !$rose(flags_o[8]));

  a_r7_trap_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && flags_o[8]) |=> (trap_req_o && push_img_o[8] && !flags_o[8]));

  a_r7_no_spurious_trap: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_i && flags_o[8]) |=> !trap_req_o);

  a_r9_direction: assert property (@(posedge clk) disable iff (!rst_n)
    dir_dec_o == flags_o[10]);
endmodule

bind flag_word_unit flg_chk u_chk (.*);

// File: tb/sim_flag_word_unit.sv
module sim_flag_word_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        retire_i, ie_set_i, ie_clr_i, img_ld_i, pmode_i;
  logic [5:0]  st_we_i, st_val_i;
  logic [15:0] img_i;
  logic [1:0]  cpl_i;
  logic [15:0] flags_o, push_img_o;
  logic        int_en_o, dir_dec_o, trap_req_o, prot_fault_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] e_word, e_push;
  logic        e_trap, e_fault;

  always #4 clk = ~clk;

  flag_word_unit u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int pos_of(input int i);
    int p[6] = '{0, 2, 4, 6, 7, 11};
    return p[i];
  endfunction

  // reference step: returns nothing, updates e_* from the requirements
  task automatic model_step();
    logic [15:0] n;
    logic ok, fire;
    ok   = !pmode_i || (cpl_i <= e_word[13:12]);
    fire = retire_i && e_word[8];
    n = e_word;
    if (img_ld_i) begin
      n = img_i & 16'h7FD5;
      n[9] = ok ? img_i[9] : e_word[9];
    end else begin
      for (int i = 0; i < 6; i++) if (st_we_i[i]) n[pos_of(i)] = st_val_i[i];
      if ((ie_set_i || ie_clr_i) && ok) n[9] = !ie_clr_i;
    end
    e_fault = (ie_set_i || ie_clr_i) && !ok;
    e_trap  = fire;
    if (fire) begin
      e_push = n;
      e_push[8] = 1'b1;
      n[8] = 1'b0;
    end
    e_word = n;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    #1;
    chk("R1 R2 R3 word", flags_o, e_word);
    chk("R4 R5 int_en", {15'd0, int_en_o}, {15'd0, e_word[9]});
    chk("R9 dir", {15'd0, dir_dec_o}, {15'd0, e_word[10]});
    chk("R5 fault", {15'd0, prot_fault_o}, {15'd0, e_fault});
    chk("R6 R7 R8 trap", {15'd0, trap_req_o}, {15'd0, e_trap});
    chk("R7 push", push_img_o, e_push);
    @(negedge clk);
  endtask

  task automatic idle();
    retire_i = 0; ie_set_i = 0; ie_clr_i = 0; img_ld_i = 0;
    st_we_i = 0; st_val_i = 0; img_i = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0286));
    idle(); pmode_i = 0; cpl_i = 0; rst_n = 0;
    e_word = 0; e_push = 0; e_trap = 0; e_fault = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 reset word", flags_o, 16'h0000);
    chk("R1 reset trap", {15'd0, trap_req_o}, 16'h0000);
    // R1 reserved bits read 0 after loading all ones
    img_ld_i = 1; img_i = 16'hFFFF; cyc(); idle();
    chk("R1 reserved", flags_o & 16'h802A, 16'h0000);
    // R4 clear wins when both set
    ie_set_i = 1; ie_clr_i = 1; cyc(); idle();
    chk("R4 clear wins", {15'd0, int_en_o}, 16'h0000);
    // R6 trap bit armed (from image above): retire traps next cycle
    retire_i = 1; cyc(); idle();
    chk("R7 push has trap bit", {15'd0, push_img_o[8]}, 16'h0001);
    // R6 load TF with retire in same cycle: no trap, next retire traps
    img_ld_i = 1; img_i = 16'h0100; retire_i = 1; cyc(); idle();
    chk("R6 no trap on loading retire", {15'd0, trap_req_o}, 16'h0000);
    retire_i = 1; cyc(); idle();
    chk("R6 trap after next retire", {15'd0, trap_req_o}, 16'h0001);
    // R5 denied: pmode, cpl 3, iopl 0
    pmode_i = 1; cpl_i = 3; ie_set_i = 1; cyc(); idle();
    chk("R5 denied keeps ie", {15'd0, int_en_o}, 16'h0000);
    img_ld_i = 1; img_i = 16'h0300; cyc(); idle();
    chk("R5 image keeps ie", {15'd0, int_en_o}, 16'h0000);
    // R8 trap fires with cpl 3 in pmode
    retire_i = 1; cyc(); idle();
    chk("R8 trap not gated", {15'd0, trap_req_o}, 16'h0001);
    pmode_i = 0; cpl_i = 0;
    // R9 direction
    img_ld_i = 1; img_i = 16'h0400; cyc(); idle();
    chk("R9 decrement", {15'd0, dir_dec_o}, 16'h0001);
    // random
    for (int k = 0; k < 3000; k++) begin
      retire_i = ($urandom_range(0, 2) == 0);
      st_we_i  = 6'($urandom());
      st_val_i = 6'($urandom());
      ie_set_i = ($urandom_range(0, 5) == 0);
      ie_clr_i = ($urandom_range(0, 5) == 0);
      img_ld_i = ($urandom_range(0, 6) == 0);
      img_i    = 16'($urandom());
      cpl_i    = 2'($urandom());
      pmode_i  = ($urandom_range(0, 1) == 0);
      cyc();
    end
    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule